// File: doc/BRIEF.md
# Transmit Clock Failover Controller

This block supervises an external transmit clock and fails over to a backup source when that clock stops. The external clock is treated as data. It passes through a synchronizer clocked by a free-running system clock. A counter then measures how long it has been since the last rising edge. If no edge arrives within a detection window, the block declares the clock lost. The window is a programmable base count divided by the configured rate multiple.

What the block does on a loss depends on how the transmit clock is built. In direct mode, the external clock is the transmit clock, so the block points the transmit clock select at the internal oscillator. In oscillator mode, the oscillator already produces the transmit clock and only uses the external clock as its reference, so the block points the oscillator reference select at the system reference instead. Each of these actions sets its own sticky status bit, and each bit has its own interrupt mask.

A switched select stays switched until software asks for a restore. The restore is honoured only once the external clock has run cleanly for a full detection window.

Top module: `txclk_failover`

## Requirements
- R1: `los` goes to 1 when no synchronized rising edge of `ext_clk` has been seen for a full detection window of `sys_clk` cycles. It returns to 0 on the next synchronized rising edge.
- R2: The detection window is `base_limit` shifted right by the value of `rate_sel`. Codes 0, 1, 2, 3 and 4 stand for rate multiples ×1, ×2, ×4, ×8 and ×16. Codes 5 to 7 use the unshifted `base_limit`. A window that works out to 0 is treated as 1.
- R3: While `auto_en` is 0, a loss changes neither select and sets no status bit.
- R4: With `auto_en`=1 and `mode`=0 (direct), a loss sets `txclk_sel` to 1 (oscillator output) and sets `status[0]`. `ref_sel` is left unchanged.
- R5: With `auto_en`=1 and `mode`=1 (oscillator), a loss sets `ref_sel` to 1 (system reference) and sets `status[1]`. `txclk_sel` is left unchanged.
- R6: Status bits are sticky. A 1 on `clr_stat[i]` clears `status[i]`. A new switch event in the same cycle wins over the clear.
- R7: `irq` is 1 exactly when some bit i has both `status[i]` and `mask[i]` equal to 1.
- R8: `txclk_sel` and `ref_sel` hold their switched value until `restore` is pulsed. The pulse returns both selects to 0 only if `los` is 0 and the clock has been present for at least one full window. Otherwise the pulse is ignored.
- R9: After reset, `los`, `txclk_sel`, `ref_sel`, `status` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External transmit clock, sampled as data |
| auto_en | input | 1 | Automatic switching enable |
| mode | input | 1 | 0: direct, 1: oscillator |
| rate_sel | input | 3 | Rate multiple code for the external clock |
| base_limit | input | CNT_W | Detection window at the ×1 rate, in sys_clk cycles |
| mask | input | 2 | Interrupt enable per status bit |
| clr_stat | input | 2 | Write-1 clear per status bit |
| restore | input | 1 | Request to return both selects to the external clock |
| los | output | 1 | Current loss-of-clock level |
| txclk_sel | output | 1 | Transmit clock select, 1 = oscillator output |
| ref_sel | output | 1 | Oscillator reference select, 1 = system reference |
| status | output | 2 | Sticky switch status, bit 0 direct, bit 1 oscillator |
| irq | output | 1 | Masked interrupt |

## Verification
On every cycle, the assertions check that a select can only rise after a loss in the matching mode with switching enabled. They also check that a select only falls after a restore while the clock is present, that a status bit only drops after its clear, and that an oscillator-mode switch leaves the transmit select untouched. Only the bench scenarios can show that loss appears at the right time for each rate code. They also show that a restore made too soon is refused, that a disabled controller ignores a loss, and how the masks shape `irq`.

// File: rtl/txfo_pkg.sv
package txfo_pkg;
  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_OSC    = 1'b1
  } clk_mode_e;

  localparam int unsigned NUM_RATES = 5;
  localparam int unsigned STAT_W    = 2;
  localparam int unsigned ST_DIRECT = 0;
  localparam int unsigned ST_OSC    = 1;
endpackage

// File: rtl/txfo_sync.sv
module txfo_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/txfo_loss_det.sv
module txfo_loss_det #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [2:0]       rate_sel,
  input  logic [CNT_W-1:0] base_limit,
  output logic             los,
  output logic             present
);
  logic [CNT_W-1:0] shifted;
  logic [CNT_W-1:0] thresh;
  logic [CNT_W-1:0] gap_q, gap_d;
  logic [CNT_W-1:0] good_q, good_d;
  logic             los_q, los_d;

  always_comb begin
    if (rate_sel < 3'(txfo_pkg::NUM_RATES)) shifted = base_limit >> rate_sel;
    else                                     shifted = base_limit;
    thresh = (shifted == '0) ? CNT_W'(1) : shifted;
  end

  always_comb begin
    gap_d  = gap_q;
    good_d = good_q;
    if (rise)                gap_d = '0;
    else if (gap_q < thresh) gap_d = gap_q + 1'b1;
    los_d = !rise && (gap_d >= thresh);
    if (los_q)                good_d = '0;
    else if (good_q < thresh) good_d = good_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      good_q <= '0;
      los_q  <= 1'b0;
    end else begin
      gap_q  <= gap_d;
      good_q <= good_d;
      los_q  <= los_d;
    end
  end

  assign los     = los_q;
  assign present = !los_q && (good_q >= thresh);
endmodule

// File: rtl/txfo_sel_ctrl.sv
module txfo_sel_ctrl
  import txfo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              los,
  input  logic              present,
  input  logic              auto_en,
  input  logic              mode,
  input  logic              restore,
  input  logic [STAT_W-1:0] clr_stat,
  output logic              txclk_sel,
  output logic              ref_sel,
  output logic [STAT_W-1:0] status
);
  logic              tx_q, tx_d, ref_q, ref_d;
  logic [STAT_W-1:0] st_q, st_d;
  logic              sw_direct, sw_osc, do_restore;

  always_comb begin
    sw_direct  = los && auto_en && (mode == MODE_DIRECT) && !tx_q;
    sw_osc     = los && auto_en && (mode == MODE_OSC) && !ref_q;
    do_restore = restore && present;
    tx_d  = do_restore ? 1'b0 : (sw_direct ? 1'b1 : tx_q);
    ref_d = do_restore ? 1'b0 : (sw_osc ? 1'b1 : ref_q);
    st_d  = st_q & ~clr_stat;
    if (sw_direct) st_d[ST_DIRECT] = 1'b1;
    if (sw_osc)    st_d[ST_OSC]    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= 1'b0;
      ref_q <= 1'b0;
      st_q  <= '0;
    end else begin
      tx_q  <= tx_d;
      ref_q <= ref_d;
      st_q  <= st_d;
    end
  end

  assign txclk_sel = tx_q;
  assign ref_sel   = ref_q;
  assign status    = st_q;
endmodule

// File: rtl/txclk_failover.sv
module txclk_failover #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             auto_en,
  input  logic             mode,
  input  logic [2:0]       rate_sel,
  input  logic [CNT_W-1:0] base_limit,
  input  logic [1:0]       mask,
  input  logic [1:0]       clr_stat,
  input  logic             restore,
  output logic             los,
  output logic             txclk_sel,
  output logic             ref_sel,
  output logic [1:0]       status,
  output logic             irq
);
  logic rise;
  logic present;

  txfo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(sys_clk), .rst_n(rst_n), .async_in(ext_clk), .rise(rise)
  );

  txfo_loss_det #(.CNT_W(CNT_W)) u_det (
    .clk(sys_clk), .rst_n(rst_n), .rise(rise), .rate_sel(rate_sel),
    .base_limit(base_limit), .los(los), .present(present)
  );

  txfo_sel_ctrl u_ctrl (
    .clk(sys_clk), .rst_n(rst_n), .los(los), .present(present),
    .auto_en(auto_en), .mode(mode), .restore(restore), .clr_stat(clr_stat),
    .txclk_sel(txclk_sel), .ref_sel(ref_sel), .status(status)
  );

  assign irq = |(status & mask);
endmodule

// File: rtl/txclk_failover_chk.sv
module txclk_failover_chk (
  input logic       sys_clk,
  input logic       rst_n,
  input logic       auto_en,
  input logic       mode,
  input logic       restore,
  input logic [1:0] clr_stat,
  input logic       los,
  input logic       txclk_sel,
  input logic       ref_sel,
  input logic [1:0] status
);
  p_txsel_rise_r4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(txclk_sel) |-> $past(los && auto_en && !mode));

  p_refsel_rise_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(ref_sel) |-> $past(los && auto_en && mode));

  p_osc_keeps_tx_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(ref_sel) |-> $stable(txclk_sel));

  p_no_switch_off_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $past(!auto_en) |-> !$rose(txclk_sel) && !$rose(ref_sel));

  p_sel_hold_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ($fell(txclk_sel) || $fell(ref_sel)) |-> $past(restore && !los));

  p_sticky0_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(status[0]) |-> $past(clr_stat[0]));

  p_sticky1_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(status[1]) |-> $past(clr_stat[1]));
endmodule

bind txclk_failover txclk_failover_chk u_chk (
  .sys_clk(sys_clk), .rst_n(rst_n), .auto_en(auto_en), .mode(mode),
  .restore(restore), .clr_stat(clr_stat), .los(los), .txclk_sel(txclk_sel),
  .ref_sel(ref_sel), .status(status)
);

// File: tb/txclk_failover_tb.sv
module txclk_failover_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          sys_clk = 1'b0;
  logic          rst_n;
  logic          ext_clk;
  logic          ext_run;
  logic          auto_en, mode, restore;
  logic [2:0]    rate_sel;
  logic [CW-1:0] base_limit;
  logic [1:0]    mask, clr_stat;
  logic          los, txclk_sel, ref_sel, irq;
  logic [1:0]    status;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

  txclk_failover #(.CNT_W(CW)) u_dut (
    .sys_clk(sys_clk), .rst_n(rst_n), .ext_clk(ext_clk), .auto_en(auto_en),
    .mode(mode), .rate_sel(rate_sel), .base_limit(base_limit), .mask(mask),
    .clr_stat(clr_stat), .restore(restore), .los(los), .txclk_sel(txclk_sel),
    .ref_sel(ref_sel), .status(status), .irq(irq)
  );

  // external clock: toggles every 2 system cycles while running
  initial begin
    ext_clk = 1'b0;
    forever begin
      @(negedge sys_clk);
      if (ext_run) begin
        @(negedge sys_clk);
        ext_clk = ~ext_clk;
      end else ext_clk = 1'b0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_run = 1'b0; auto_en = 1'b1; mode = 1'b0; restore = 1'b0;
    rate_sel = 3'd0; base_limit = 16'd64; mask = 2'b00; clr_stat = 2'b00;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_restore();
    restore = 1'b1; tick(1); restore = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk(los == 0 && txclk_sel == 0 && ref_sel == 0 && status == 0 && irq == 0,
        "R9 reset state", {los, txclk_sel, ref_sel, status, irq}, 0);
  endtask

  task automatic t_detect();
    do_reset();
    ext_run = 1'b1; tick(100);
    chk(los == 0, "R1 running clock no loss", los, 0);
    ext_run = 1'b0; tick(58);
    chk(los == 0, "R1 before window", los, 0);
    tick(12);
    chk(los == 1, "R1 after window", los, 1);
    ext_run = 1'b1; tick(8);
    chk(los == 0, "R1 clears on edge", los, 0);
  endtask

  task automatic t_rate(input logic [2:0] code, input int win);
    do_reset();
    base_limit = 16'd256; rate_sel = code;
    ext_run = 1'b1; tick(40);
    ext_run = 1'b0; tick(win - 6);
    chk(los == 0, $sformatf("R2 code %0d before window", code), los, 0);
    tick(12);
    chk(los == 1, $sformatf("R2 code %0d after window", code), los, 1);
  endtask

  task automatic t_auto_off();
    do_reset();
    auto_en = 1'b0; mask = 2'b11;
    ext_run = 1'b1; tick(80); ext_run = 1'b0; tick(100);
    chk(los == 1, "R3 loss seen", los, 1);
    chk(txclk_sel == 0 && ref_sel == 0 && status == 0 && irq == 0,
        "R3 no switch when disabled", {txclk_sel, ref_sel, status, irq}, 0);
  endtask

  task automatic t_direct();
    do_reset();
    mode = 1'b0; mask = 2'b01;
    ext_run = 1'b1; tick(80);
    chk(txclk_sel == 0 && irq == 0, "R4 idle before loss", {txclk_sel, irq}, 0);
    ext_run = 1'b0; tick(80);
    chk(txclk_sel == 1, "R4 tx select switched", txclk_sel, 1);
    chk(ref_sel == 0, "R4 ref select unchanged", ref_sel, 0);
    chk(status == 2'b01, "R4 status bit 0", status, 1);
    chk(irq == 1, "R7 irq with mask 0", irq, 1);
    mask = 2'b10; tick(1);
    chk(irq == 0, "R7 irq masked", irq, 0);
    clr_stat = 2'b10; tick(1); clr_stat = 2'b00; tick(1);
    chk(status == 2'b01, "R6 wrong-bit clear ignored", status, 1);
    clr_stat = 2'b01; tick(1); clr_stat = 2'b00; tick(1);
    chk(status == 2'b00, "R6 write-1 clear", status, 0);
    chk(txclk_sel == 1, "R8 select holds without restore", txclk_sel, 1);
  endtask

  task automatic t_osc();
    do_reset();
    mode = 1'b1; mask = 2'b01;
    ext_run = 1'b1; tick(80); ext_run = 1'b0; tick(80);
    chk(ref_sel == 1, "R5 ref select switched", ref_sel, 1);
    chk(txclk_sel == 0, "R5 tx select unchanged", txclk_sel, 0);
    chk(status == 2'b10, "R5 status bit 1", status, 2);
    chk(irq == 0, "R7 bit 1 not enabled", irq, 0);
    mask = 2'b10; tick(1);
    chk(irq == 1, "R7 bit 1 enabled", irq, 1);
  endtask

  task automatic t_restore();
    do_reset();
    mode = 1'b0;
    ext_run = 1'b1; tick(80); ext_run = 1'b0; tick(80);
    chk(txclk_sel == 1, "R8 setup switched", txclk_sel, 1);
    pulse_restore();
    chk(txclk_sel == 1, "R8 restore during loss ignored", txclk_sel, 1);
    ext_run = 1'b1; tick(12);
    chk(los == 0, "R8 clock back", los, 0);
    pulse_restore();
    chk(txclk_sel == 1, "R8 early restore ignored", txclk_sel, 1);
    tick(90);
    pulse_restore();
    chk(txclk_sel == 0 && ref_sel == 0, "R8 restore accepted", {txclk_sel, ref_sel}, 0);
    chk(status == 2'b01, "R6 status survives restore", status, 1);
  endtask

  initial begin
    t_reset();
    t_detect();
    t_rate(3'd0, 256);
    t_rate(3'd2, 64);
    t_rate(3'd4, 16);
    t_rate(3'd6, 256);
    t_auto_off();
    t_direct();
    t_osc();
    t_restore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule